// File: doc/BRIEF.md
# Registered Pin Bank with Atomic Alias Windows

This block gives a processor direct register control over a bank of general-purpose pins, with no peripheral multiplexing in the path. It holds two state registers. One register sets the level driven on each pin. The other enables each pin's output driver. It also offers two read-only views of the pin inputs. The first view returns the pins exactly as they arrive. The second returns them after a synchroniser clocked by the system clock.

The whole register set can be reached through four address windows. A write through the first window stores the written word. A write through the second window toggles the bits that are set in the written word. A write through the third window sets those bits, and a write through the fourth window clears them. Software can therefore change one pin with a single bus write, and needs no read-modify-write sequence that another bus master could interrupt.

The bus is a plain single-cycle register port and carries no stream. A write takes effect on the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from the current state in the same cycle that `bus_sel` is high. The port never stalls, so it has no back-pressure.

Top module: `rio_bank`

## Requirements
- R1: After reset, both state registers are zero. `pin_out` and `pin_oe` are all low, and a read of the output or enable register returns 0.
- R2: In window 0, a write to offset 0x0 loads the output register and a write to offset 0x4 loads the enable register with `bus_wdata[27:0]`. A read in the next cycle returns the stored value.
- R3: In window 1 (address bits [13:12] = 1, e.g. 0x1000/0x1004), a write XORs `bus_wdata[27:0]` into the addressed register.
- R4: In window 2 (address bits [13:12] = 2, e.g. 0x2000/0x2004), a write ORs `bus_wdata[27:0]` into the addressed register.
- R5: In window 3 (address bits [13:12] = 3, e.g. 0x3000/0x3004), a write clears every bit of the addressed register that is set in `bus_wdata[27:0]`.
- R6: A read (`bus_we` low) through any window returns the register value and leaves both registers unchanged.
- R7: A read of offset 0x8, in any window, returns `pin_in` in the same cycle.
- R8: A read of offset 0xC, in any window, returns `pin_in` as it was two rising clock edges earlier. A change is not visible after one edge and is visible after the second edge.
- R9: Writes to offsets 0x8 and 0xC in any window change nothing. Read data bits 31:28 are always 0.
- R10: `pin_out` always equals the output register and `pin_oe` always equals the enable register. An update shows on the pins right after the write's clock edge.
- R11: When `bus_sel` is low, no write happens whatever `bus_we` is, and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address; [13:12] window, [3:2] register |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pin_out | output | 28 | Level driven on each pin |
| pin_oe | output | 28 | Output-driver enable for each pin |
| pin_in | input | 28 | Pin levels from the pads |

## Verification
The properties assume that `bus_sel`, `bus_we` and `bus_addr` are known at every clock edge. They also assume that `pin_in` never changes exactly on a rising edge, so the two-edge history of the synchronised view is well defined. The stimulus drives every bus and pin input at the falling edge and samples results just after it. The synchronised-input check runs only once enough edges have passed since reset for the history to exist.

// File: rtl/rio_pkg.sv
package rio_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_FLIP  = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    SEL_OUT  = 2'd0,
    SEL_OE   = 2'd1,
    SEL_RAW  = 2'd2,
    SEL_SYNC = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rio_addr_dec.sv
module rio_addr_dec
  import rio_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_LSB = 12,
  parameter int REG_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output alias_op_e         op,
  output reg_sel_e          rsel
);
  logic unused_addr;
  assign unused_addr = ^addr;

  assign op   = alias_op_e'(addr[WIN_LSB+1:WIN_LSB]);
  assign rsel = reg_sel_e'(addr[REG_LSB+1:REG_LSB]);
endmodule

// File: rtl/rio_alias_reg.sv
module rio_alias_reg
  import rio_pkg::*;
#(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  alias_op_e    op,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    case (op)
      OP_LOAD: nxt = mask;
      OP_FLIP: nxt = q ^ mask;
      OP_SET:  nxt = q | mask;
      default: nxt = q & ~mask;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/rio_sync.sv
module rio_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rio_bank.sv
module rio_bank
  import rio_pkg::*;
#(
  parameter int NUM_PINS    = 28,
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 16,
  parameter int WIN_LSB     = 12,
  parameter int REG_LSB     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic [NUM_PINS-1:0] pin_in
);
  localparam int PAD_W = BUS_W - NUM_PINS;

  alias_op_e op;
  reg_sel_e  rsel;
  logic      wr_out, wr_oe;
  logic [NUM_PINS-1:0] mask, out_q, oe_q, sync_q, rd_pins;
  logic unused_wdata;

  assign mask         = bus_wdata[NUM_PINS-1:0];
  assign unused_wdata = ^bus_wdata;

  rio_addr_dec #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .REG_LSB(REG_LSB)) u_dec (
    .addr(bus_addr), .op(op), .rsel(rsel)
  );

  assign wr_out = bus_sel && bus_we && (rsel == SEL_OUT);
  assign wr_oe  = bus_sel && bus_we && (rsel == SEL_OE);

  rio_alias_reg #(.W(NUM_PINS)) u_out_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_out), .op(op), .mask(mask), .q(out_q)
  );

  rio_alias_reg #(.W(NUM_PINS)) u_oe_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_oe), .op(op), .mask(mask), .q(oe_q)
  );

  rio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  always_comb begin
    case (rsel)
      SEL_OUT: rd_pins = out_q;
      SEL_OE:  rd_pins = oe_q;
      SEL_RAW: rd_pins = pin_in;
      default: rd_pins = sync_q;
    endcase
  end

  assign bus_rdata = bus_sel ? {{PAD_W{1'b0}}, rd_pins} : '0;
  assign pin_out   = out_q;
  assign pin_oe    = oe_q;
endmodule

// File: rtl/rio_bank_chk.sv
module rio_bank_chk #(
  parameter int NUM_PINS    = 28,
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 16,
  parameter int WIN_LSB     = 12,
  parameter int REG_LSB     = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_in
);
  logic [1:0] win, rg;
  logic [NUM_PINS-1:0] m;
  logic [3:0] since_rst;
  logic wr;
  logic unused_chk;

  assign win = bus_addr[WIN_LSB+1:WIN_LSB];
  assign rg  = bus_addr[REG_LSB+1:REG_LSB];
  assign m   = bus_wdata[NUM_PINS-1:0];
  assign wr  = bus_sel && bus_we;
  assign unused_chk = ^{bus_addr, bus_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  // R1: reset clears the pin-side state
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_out == '0) && (pin_oe == '0));

  // R2: plain load through window 0
  assert_plain_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win == 2'd0 && rg == 2'd0) |=> pin_out == $past(m));

  // R3: toggle window
  assert_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win == 2'd1 && rg == 2'd0) |=> pin_out == ($past(pin_out) ^ $past(m)));

  // R4: set window
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win == 2'd2 && rg == 2'd1) |=> pin_oe == ($past(pin_oe) | $past(m)));

  // R5: clear window
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win == 2'd3 && rg == 2'd1) |=> pin_oe == ($past(pin_oe) & ~$past(m)));

  // R6, R11: no write strobe means no change
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(pin_out) && $stable(pin_oe));

  // R7: raw input view
  assert_raw_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && rg == 2'd2) |-> bus_rdata[NUM_PINS-1:0] == pin_in);

  // R8: synchronised input view lags by the stage count
  assert_sync_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && rg == 2'd3 && since_rst >= SYNC_STAGES)
      |-> bus_rdata[NUM_PINS-1:0] == $past(pin_in, SYNC_STAGES));

  // R9: upper read bits stay zero
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:NUM_PINS] == '0);

  // R11: idle bus reads zero
  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);
endmodule

bind rio_bank rio_bank_chk #(
  .NUM_PINS(NUM_PINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
  .WIN_LSB(WIN_LSB), .REG_LSB(REG_LSB), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
);

// File: tb/sim_rio_bank.sv
module sim_rio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [27:0] pin_out, pin_oe;
  logic [27:0] pin_in = '0;

  int checks = 0;
  int errors = 0;
  logic [27:0] exp_out = '0;
  logic [27:0] exp_oe = '0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  rio_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic check_state(input string req);
    logic [31:0] v;
    rd(16'h0000, v); chk(req, v, {4'h0, exp_out});
    rd(16'h0004, v); chk(req, v, {4'h0, exp_oe});
    #1;
    chk(req, {4'h0, pin_out}, {4'h0, exp_out});
    chk(req, {4'h0, pin_oe},  {4'h0, exp_oe});
  endtask

  task automatic t_reset;
    #1 chk("R1 pin_out", {4'h0, pin_out}, 32'h0);
    chk("R1 pin_oe", {4'h0, pin_oe}, 32'h0);
    check_state("R1");
  endtask

  task automatic t_plain;
    wr(16'h0000, 32'hA5A5_5A5A); exp_out = 28'h5A5_5A5A;
    #1 chk("R10 pin_out after load", {4'h0, pin_out}, 32'h05A5_5A5A);
    wr(16'h0004, 32'hF0FF_00FF); exp_oe = 28'h0FF_00FF;
    check_state("R2 R9 plain load");
  endtask

  task automatic t_flip;
    wr(16'h1000, 32'h0000_FFFF); exp_out = exp_out ^ 28'h000_FFFF;
    check_state("R3 flip out");
    wr(16'h1004, 32'h0300_0003); exp_oe = exp_oe ^ 28'h300_0003;
    check_state("R3 flip oe");
    wr(16'h1000, 32'h0000_FFFF); exp_out = exp_out ^ 28'h000_FFFF;
    check_state("R3 flip back");
  endtask

  task automatic t_set;
    wr(16'h2004, 32'h0F00_0000); exp_oe = exp_oe | 28'hF00_0000;
    check_state("R4 set oe");
    wr(16'h2000, 32'h8000_0001); exp_out = exp_out | 28'h000_0001;
    check_state("R4 set out");
  endtask

  task automatic t_clear;
    wr(16'h3000, 32'h0000_00F0); exp_out = exp_out & ~28'h000_00F0;
    check_state("R5 clear out");
    wr(16'h3004, 32'hFFFF_FFFF); exp_oe = '0;
    check_state("R5 clear all oe");
  endtask

  task automatic t_reads;
    logic [31:0] v;
    wr(16'h0004, 32'h0123_4567); exp_oe = 28'h123_4567;
    for (int w = 1; w < 4; w++) begin
      rd(16'(w << 12), v);       chk("R6 alias read out", v, {4'h0, exp_out});
      rd(16'((w << 12) | 4), v); chk("R6 alias read oe", v, {4'h0, exp_oe});
    end
    check_state("R6 unchanged after alias reads");
  endtask

  task automatic t_raw;
    logic [31:0] v;
    pin_in = 28'hABC_DEF1;
    rd(16'h0008, v); chk("R7 raw in", v, 32'h0ABC_DEF1);
    pin_in = 28'h135_7924;
    rd(16'h2008, v); chk("R7 raw in alias", v, 32'h0135_7924);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    pin_in = 28'h111_1111;
    repeat (4) @(negedge clk);
    pin_in = 28'h0EE_0EE0;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 16'h000C;
    #1 chk("R8 sync before edge", bus_rdata, 32'h0111_1111);
    @(posedge clk); @(negedge clk);
    #1 chk("R8 sync after one edge", bus_rdata, 32'h0111_1111);
    @(posedge clk); @(negedge clk);
    #1 chk("R8 sync after two edges", bus_rdata, 32'h00EE_0EE0);
    bus_sel = 1'b0;
    rd(16'h300C, v); chk("R8 sync alias", v, 32'h00EE_0EE0);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(16'h0008, 32'hFFFF_FFFF);
    wr(16'h000C, 32'hFFFF_FFFF);
    wr(16'h1008, 32'hFFFF_FFFF);
    wr(16'h200C, 32'hFFFF_FFFF);
    wr(16'h3008, 32'hFFFF_FFFF);
    check_state("R9 input writes ignored");
    rd(16'h0008, v); chk("R9 raw in intact", v, {4'h0, pin_in});
  endtask

  task automatic t_nosel;
    bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 16'h0000; bus_wdata = 32'h0FFF_FFFF;
    #1 chk("R11 idle rdata", bus_rdata, 32'h0);
    @(posedge clk); @(negedge clk);
    bus_addr = 16'h2004;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    check_state("R11 unselected write ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_flip();
    t_set();
    t_clear();
    t_reads();
    t_raw();
    t_sync();
    t_readonly();
    t_nosel();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule